// File: doc/BRIEF.md
# Always-On Rail Power Sequencer

This block drives the power-down and power-up sequences of a platform's always-on rail group. A forced-off request holds the host in reset, then drops the auxiliary rail group and then the 5 V rail, one step per clock. The block waits a fixed settle interval and then checks once per millisecond tick whether the rails have collapsed. If the 5 V power-good or the core power-good summary is still high when the poll budget runs out, the sequence still ends in the off state and raises a timeout flag, so it cannot hang.

A power-on request turns on the 5 V rail first and the auxiliary group one cycle later. The host reset is released only once the 5 V power-good is seen. Both power-good inputs pass through a two-stage synchronizer. The millisecond tick comes from an internal prescaler, and its period, the settle count and the poll count are parameters, so a bench can use short values.

Top module: `pwr_rail_seq`

## Requirements
- R1: After reset, host_rst_no, aux_en_o, main5v_en_o, done_o and timeout_o are all 0.
- R2: An on_req_i accepted in the off state sets main5v_en_o on the next clock edge and aux_en_o one edge later.
- R3: host_rst_no rises only in the ready state, after both enables are high and the synchronized 5 V power-good is high. done_o is high for exactly that one cycle. The wait for power-good has no time limit.
- R4: An accepted off_req_i drives host_rst_no low on the next edge. aux_en_o goes low one edge later and main5v_en_o one edge after that.
- R5: The tick prescaler restarts on the edge that drops main5v_en_o. The power-good inputs are ignored for the next SETTLE_TICKS ticks. The first poll therefore happens at tick SETTLE_TICKS+1, which is the edge 2+(SETTLE_TICKS+1)*TICK_DIV edges after the accepting edge.
- R6: At each poll tick, if both synchronized power-goods are low, the block goes to the off state with a one-cycle done_o, timeout_o low and all rails disabled.
- R7: If the POLL_TICKS-th poll still sees either power-good high, the block goes to the off state with done_o and timeout_o set. timeout_o then holds until the next accepted request.
- R8: Requests are ignored while a sequence runs. on_req_i is also ignored in the on state.
- R9: off_req_i is accepted in both the on and the off state. If off_req_i and on_req_i arrive together, the shutdown sequence wins and main5v_en_o stays low.
- R10: Each power-good input passes through two flip-flops. A 5 V power-good rise during the ready wait releases host_rst_no on the third edge after the input changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| off_req_i | input | 1 | Forced power-down request |
| on_req_i | input | 1 | Power-up request |
| pg_5v_i | input | 1 | 5 V rail power-good (asynchronous) |
| pg_core_i | input | 1 | Core power-good summary (asynchronous) |
| host_rst_no | output | 1 | Reset to host, active low |
| aux_en_o | output | 1 | Auxiliary rail group enable |
| main5v_en_o | output | 1 | 5 V rail enable |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| timeout_o | output | 1 | Last power-down ended on the poll timeout |

## Verification
The bound checker checks on every cycle:
- the ordering of the enable and reset edges in both directions;
- that the host reset is released only with the rails on and a power-good seen two samples earlier;
- that every completed power-down leaves all rails off, after at least the settle interval;
- that a timeout is only ever raised together with done.

The exact completion cycle cannot be checked by a property. The bench scenarios measure it against a schedule computed from the tick grid, with power-good drops placed just before and just after a poll tick and at the last poll. The scenarios also show that mid-sequence requests change nothing, that shutdown wins when both requests arrive together, and that timeout_o persists until the next request.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_AUX,
        ST_UP_WAIT,
        ST_ON,
        ST_DN_AUX,
        ST_DN_5V,
        ST_DN_SETTLE,
        ST_DN_POLL
    } seq_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsq_tick.sv
module rsq_tick #(
    parameter int unsigned TICK_DIV = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import rsq_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned SETTLE_TICKS = 10,
    parameter int unsigned POLL_TICKS   = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic off_req_i,
    input  logic on_req_i,
    input  logic pg_5v_i,
    input  logic pg_core_i,
    output logic host_rst_no,
    output logic aux_en_o,
    output logic main5v_en_o,
    output logic done_o,
    output logic timeout_o
);

    localparam int unsigned MAXC  = (SETTLE_TICKS > POLL_TICKS) ? SETTLE_TICKS : POLL_TICKS;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_TICKS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             hrst_n;
        logic             aux;
        logic             v5;
        logic             done;
        logic             tmo;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state: ST_OFF, cnt: '0, hrst_n: 1'b0, aux: 1'b0, v5: 1'b0, done: 1'b0, tmo: 1'b0
    };

    seq_regs_t d, q;
    logic [1:0] pg_sync;
    logic       pg5_s, pgc_s;
    logic       tick, tick_clr;

    rsq_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({pg_core_i, pg_5v_i}),
        .sync_o  (pg_sync)
    );

    assign pg5_s = pg_sync[0];
    assign pgc_s = pg_sync[1];

    rsq_tick #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tick_clr = 1'b0;
        unique case (q.state)
            ST_OFF, ST_ON: begin
                if (off_req_i) begin
                    d.tmo    = 1'b0;
                    d.hrst_n = 1'b0;
                    d.state  = ST_DN_AUX;
                end else if (on_req_i && q.state == ST_OFF) begin
                    d.tmo   = 1'b0;
                    d.v5    = 1'b1;
                    d.state = ST_UP_AUX;
                end
            end
            ST_UP_AUX: begin
                d.aux   = 1'b1;
                d.state = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (pg5_s) begin
                    d.hrst_n = 1'b1;
                    d.done   = 1'b1;
                    d.state  = ST_ON;
                end
            end
            ST_DN_AUX: begin
                d.aux   = 1'b0;
                d.state = ST_DN_5V;
            end
            ST_DN_5V: begin
                d.v5     = 1'b0;
                d.cnt    = '0;
                tick_clr = 1'b1;
                d.state  = ST_DN_SETTLE;
            end
            ST_DN_SETTLE: begin
                if (tick) begin
                    if (q.cnt == SETTLE_LAST) begin
                        d.cnt   = '0;
                        d.state = ST_DN_POLL;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DN_POLL: begin
                if (tick) begin
                    if (!pg5_s && !pgc_s) begin
                        d.done  = 1'b1;
                        d.state = ST_OFF;
                    end else if (q.cnt == POLL_LAST) begin
                        d.done  = 1'b1;
                        d.tmo   = 1'b1;
                        d.state = ST_OFF;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RESET_VAL;
        else         q <= d;
    end

    assign host_rst_no = q.hrst_n;
    assign aux_en_o    = q.aux;
    assign main5v_en_o = q.v5;
    assign done_o      = q.done;
    assign timeout_o   = q.tmo;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned SETTLE_TICKS = 10,
    parameter int unsigned POLL_TICKS   = 50
) (
    input logic clk_i,
    input logic rst_ni,
    input logic pg_5v_i,
    input logic host_rst_no,
    input logic aux_en_o,
    input logic main5v_en_o,
    input logic done_o,
    input logic timeout_o
);

    localparam logic [31:0] MIN_LOW = 32'(SETTLE_TICKS * TICK_DIV);

    logic [31:0] low_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                low_cnt_q <= '0;
        else if (host_rst_no)       low_cnt_q <= '0;
        else if (low_cnt_q < MIN_LOW) low_cnt_q <= low_cnt_q + 1;
    end

    AST_AUX_OFF_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(aux_en_o) |-> !host_rst_no);  // R4
    AST_5V_OFF_AFTER_AUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(main5v_en_o) |-> !aux_en_o);  // R4
    AST_AUX_ON_AFTER_5V: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(aux_en_o) |-> main5v_en_o && $past(main5v_en_o));  // R2
    AST_RELEASE_RAILS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_rst_no) |-> aux_en_o && main5v_en_o && done_o);  // R3
    AST_RELEASE_PG_SYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_rst_no) |-> $past(pg_5v_i, 2));  // R10
    AST_OFF_DONE_RAILS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !host_rst_no) |-> !aux_en_o && !main5v_en_o);  // R6
    AST_SETTLE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !host_rst_no) |-> low_cnt_q >= MIN_LOW);  // R5
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> done_o && !host_rst_no);  // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);  // R6

endmodule

bind pwr_rail_seq rsq_checker #(
    .TICK_DIV     (TICK_DIV),
    .SETTLE_TICKS (SETTLE_TICKS),
    .POLL_TICKS   (POLL_TICKS)
) u_rsq_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pg_5v_i     (pg_5v_i),
    .host_rst_no (host_rst_no),
    .aux_en_o    (aux_en_o),
    .main5v_en_o (main5v_en_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
);

// File: tb/pwr_rail_seq_tb.sv
`timescale 1ns/1ps
module pwr_rail_seq_tb;

    localparam int DIV    = 20;
    localparam int SETTLE = 10;
    localparam int POLL   = 50;
    localparam int NV     = 10;
    // columns: 5 V power-good drop time, core power-good drop time, mid-sequence request time (-1 none)
    localparam int VEC [NV][3] = '{
        '{0, 0, -1}, '{100, 300, -1}, '{2000, 0, -1}, '{0, 2000, -1},
        '{219, 0, -1}, '{220, 0, -1}, '{1199, 1199, -1}, '{1200, 0, -1},
        '{0, 0, 50}, '{500, 0, 230}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic off_req = 1'b0, on_req = 1'b0, pg5 = 1'b0, pgc = 1'b0;
    logic host_rst_n, aux_en, v5_en, done, tmo;
    int   cyc = 0, checks = 0, errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_rail_seq #(.TICK_DIV(DIV), .SETTLE_TICKS(SETTLE), .POLL_TICKS(POLL)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .off_req_i(off_req), .on_req_i(on_req),
        .pg_5v_i(pg5), .pg_core_i(pgc), .host_rst_no(host_rst_n), .aux_en_o(aux_en),
        .main5v_en_o(v5_en), .done_o(done), .timeout_o(tmo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_delta(input int r5, input int rc, output bit to);
        int last = (r5 > rc) ? r5 : rc;
        for (int k = 1; k <= POLL; k++) begin
            int p = 2 + (SETTLE + k) * DIV;
            if (p >= last + 3) begin
                to = 1'b0;
                return p;
            end
        end
        to = 1'b1;
        return 2 + (SETTLE + POLL) * DIV;
    endfunction

    task automatic power_up();
        @(negedge clk); pg5 = 1'b1; pgc = 1'b1; on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        for (int i = 0; i < 20 && !host_rst_n; i++) @(negedge clk);
        chk(host_rst_n == 1'b1, "R3 power-up completes", host_rst_n, 1);
    endtask

    task automatic run_shutdown(input int r5, input int rc, input int inj, input bit both,
                                output int delta, output bit to);
        bit from_on = host_rst_n;
        int t0, rel;
        @(negedge clk); off_req = 1'b1; on_req = both;
        @(negedge clk); off_req = 1'b0; on_req = 1'b0;
        t0 = cyc;
        delta = -1; to = 1'b0;
        forever begin
            rel = cyc - t0;
            if (done) begin
                delta = rel; to = tmo;
                break;
            end
            if (from_on && rel == 0) begin
                chk(!host_rst_n && aux_en && v5_en, "R4 step1 reset low, rails on",
                    {host_rst_n, aux_en, v5_en}, 3'b011);
            end
            if (from_on && rel == 1)
                chk(!aux_en && v5_en, "R4 step2 aux off, 5V on", {aux_en, v5_en}, 2'b01);
            if (from_on && rel == 2)
                chk(!v5_en, "R4 step3 5V off", v5_en, 0);
            if (rel == r5) pg5 = 1'b0;
            if (rel == rc) pgc = 1'b0;
            if (rel == inj) begin off_req = 1'b1; on_req = 1'b1; end
            else begin off_req = 1'b0; on_req = 1'b0; end
            if (rel > 3000) break;
            @(negedge clk);
        end
        off_req = 1'b0; on_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int  dl, ed;
        bit  to, eto;
        repeat (3) @(negedge clk);
        chk({host_rst_n, aux_en, v5_en, done, tmo} == 5'b0, "R1 reset state",
            {host_rst_n, aux_en, v5_en, done, tmo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({host_rst_n, aux_en, v5_en, done, tmo} == 5'b0, "R1 idle after reset",
            {host_rst_n, aux_en, v5_en, done, tmo}, 0);

        // R9: both requests together in the off state -> shutdown wins
        run_shutdown(0, 0, -1, 1'b1, dl, to);
        chk(dl == 2 + (SETTLE + 1) * DIV, "R9 shutdown wins, completion cycle", dl, 2 + (SETTLE + 1) * DIV);
        chk(!v5_en && !aux_en, "R9 rails stay off", {aux_en, v5_en}, 0);

        // R2/R3: power-up order with power-good already high
        @(negedge clk); pg5 = 1'b1; pgc = 1'b1; on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        chk(v5_en && !aux_en, "R2 5V first", {v5_en, aux_en}, 2'b10);
        @(negedge clk);
        chk(v5_en && aux_en && !host_rst_n, "R2 aux second", {v5_en, aux_en, host_rst_n}, 3'b110);
        @(negedge clk);
        chk(host_rst_n && done, "R3 release with done", {host_rst_n, done}, 2'b11);
        @(negedge clk);
        chk(!done, "R3 done one cycle", done, 0);

        // R8: power-up request in the on state is ignored
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        repeat (3) @(negedge clk);
        chk({host_rst_n, aux_en, v5_en, done} == 4'b1110, "R8 on_req ignored when on",
            {host_rst_n, aux_en, v5_en, done}, 4'b1110);

        // R10/R3: ready wait with 5 V power-good low, then a late rise
        run_shutdown(0, 0, -1, 1'b0, dl, to);
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(!host_rst_n && v5_en && aux_en, "R3 reset held without power-good",
            {host_rst_n, aux_en, v5_en}, 3'b011);
        pg5 = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!host_rst_n, "R10 not released after two edges", host_rst_n, 0);
        @(negedge clk);
        chk(host_rst_n, "R10 released on third edge", host_rst_n, 1);

        // table of shutdown scenarios
        for (int v = 0; v < NV; v++) begin
            if (!host_rst_n) power_up();
            chk(!tmo, "R7 timeout cleared by new request", tmo, 0);
            run_shutdown(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, dl, to);
            ed = exp_delta(VEC[v][0], VEC[v][1], eto);
            chk(dl == ed, eto ? "R7 timeout completion cycle" : "R5/R6 poll completion cycle", dl, ed);
            chk(to == eto, eto ? "R7 timeout flag set" : "R6 timeout flag clear", to, eto);
            chk(!aux_en && !v5_en && !host_rst_n, "R6 all off at done",
                {host_rst_n, aux_en, v5_en}, 0);
            if (VEC[v][2] >= 0)
                chk(dl == ed && !v5_en, "R8 mid-sequence requests ignored", dl, ed);
            repeat (3) @(negedge clk);
            chk(tmo == eto, "R7 timeout holds", tmo, eto);
            chk(!v5_en, "R6 off state stable", v5_en, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule